// File: doc/BRIEF.md
# Condition-Field Lookup-Table Logic Unit

This unit holds eight 4-bit condition fields and runs two bitwise lookup-table operations on them, both taken from a 32-bit instruction word that arrives with a valid strobe. The three-input form uses an 8-bit table carried in the instruction and combines three fields bit by bit. The two-input form combines two fields bit by bit, and its 4-bit table is the current contents of a third field rather than an immediate.

The first source field is always the destination. A 4-bit write mask, also carried in the instruction, chooses which of its bits take the new result. Bits outside the mask keep their old value. Because the destination is read anyway to build the result, each operation uses exactly three field reads and one field write. An instruction whose opcodes match neither form raises an illegal flag and changes nothing. The whole field file is visible on an output bus.

Top module: `cfl_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all eight fields to 0 and drives `illegal_o` low.
- R2: Instruction layout, given as little-endian indices of `instr` (big-endian bit b is `instr[31-b]`). The primary opcode is `instr[31:26]`. BF is `instr[25:23]`. BFA is `instr[20:18]`. BFB is `instr[15:13]`. The extended opcode is `instr[5:1]`. The unit accepts only primary opcode 22. Extended opcode 10 selects the three-input form and 11 selects the two-input form.
- R3: Three-input form. The table is T = {`instr[12:6]`, `instr[0]`}. For each field bit j, the result is T[{BF[j], BFA[j], BFB[j]}], with BF as the most significant index bit. Field k appears on `cf_file_o[4k+3:4k]`, and bit 3 is the field's big-endian bit 0.
- R4: Two-input form. The table is the 4-bit value of field BFB. Each bit j gets BFB[{BF[j], BFA[j]}].
- R5: The mask is M = {`instr[22:21]`, `instr[17:16]`}. Mask bit j gates field bit j. Destination bits whose mask bit is 0 keep their old value.
- R6: With an all-zero mask, the destination field is left unchanged.
- R7: In the two-input form, `instr[12:6]` and `instr[0]` are reserved and have no effect on the result.
- R8: A valid instruction whose primary or extended opcode matches neither form sets `illegal_o` for one cycle and writes nothing. When the strobe is low, nothing is written and `illegal_o` is low.
- R9: A result is visible on `cf_file_o`, and `illegal_o` is updated, after the clock edge that samples the instruction. An instruction on the next cycle reads the updated field.
- R10: When BF, BFA and BFB name the same field, all three operands are the field's value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| illegal_o | output | 1 | Unrecognised opcode seen in the previous cycle |
| cf_file_o | output | 32 | All eight condition fields, field k at bits 4k+3..4k |

## Verification
Every result, both the field update and the illegal flag, is due exactly one rising edge after the instruction is sampled. The driver changes inputs on falling edges and queues the expected file image and flag for each cycle it drives. The monitor pops one entry on the falling edge after each sampled cycle and compares it, so back-to-back dependent instructions line up with their results without gaps. Idle cycles are queued too, which shows that a low strobe leaves the file untouched.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int TBL3_W     = 1 << 3;
    localparam int TBL2_W     = 1 << 2;
    localparam int FILE_W     = FIELD_W * NUM_FIELDS;

    localparam logic [5:0] PRI_OPC = 6'd22;
    localparam logic [4:0] XO_TERN = 5'd10;
    localparam logic [4:0] XO_BIN  = 5'd11;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_TERN = 2'd1,
        OP_BIN  = 2'd2,
        OP_ILL  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e                kind;
        logic [IDX_W-1:0]        bf;
        logic [IDX_W-1:0]        bfa;
        logic [IDX_W-1:0]        bfb;
        logic [FIELD_W-1:0]      mask;
        logic [TBL3_W-1:0]       tbl3;
    } decoded_t;

    function automatic op_kind_e classify(input logic v, input logic [5:0] opc,
                                          input logic [4:0] xo);
        if (!v)                 return OP_NONE;
        if (opc != PRI_OPC)     return OP_ILL;
        if (xo == XO_TERN)      return OP_TERN;
        if (xo == XO_BIN)       return OP_BIN;
        return OP_ILL;
    endfunction

    function automatic logic writes(input op_kind_e k);
        return (k == OP_TERN) || (k == OP_BIN);
    endfunction
endpackage

// File: rtl/cfl_decode.sv
module cfl_decode
    import cfl_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output decoded_t    dec
);
    // Field slices use little-endian indices; big-endian bit b is instr[31-b].
    always_comb begin
        dec.kind = classify(instr_valid, instr[31:26], instr[5:1]);
        dec.bf   = instr[25:23];
        dec.bfa  = instr[20:18];
        dec.bfb  = instr[15:13];
        dec.mask = {instr[22:21], instr[17:16]};
        dec.tbl3 = {instr[12:6], instr[0]};
    end
endmodule

// File: rtl/cfl_lut_lane.sv
module cfl_lut_lane
    import cfl_pkg::*;
(
    input  op_kind_e            kind,
    input  logic [TBL3_W-1:0]   tbl3,
    input  logic [TBL2_W-1:0]   tbl2,
    input  logic                a,
    input  logic                b,
    input  logic                c,
    output logic                r
);
    always_comb begin
        unique case (kind)
            OP_TERN: r = tbl3[{a, b, c}];
            OP_BIN:  r = tbl2[{a, b}];
            default: r = a;
        endcase
    end
endmodule

// File: rtl/cfl_cfile.sv
module cfl_cfile
    import cfl_pkg::*;
#(
    parameter int N = NUM_FIELDS,
    parameter int W = FIELD_W,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   ra_idx,
    input  logic [IW-1:0]   rb_idx,
    input  logic [IW-1:0]   rc_idx,
    output logic [W-1:0]    ra_data,
    output logic [W-1:0]    rb_data,
    output logic [W-1:0]    rc_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [W-1:0]    wr_mask,
    input  logic [W-1:0]    wr_data,
    output logic [N*W-1:0]  file_flat
);
    logic [W-1:0] file [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) file[k] <= '0;
        end else if (wr_en) begin
            file[wr_idx] <= (file[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assign ra_data = file[ra_idx];
    assign rb_data = file[rb_idx];
    assign rc_data = file[rc_idx];

    for (genvar k = 0; k < N; k++) begin : g_flat
        assign file_flat[k*W +: W] = file[k];
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> file_flat == '0);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(file_flat));

    assert_keep_masked_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((file[$past(wr_idx)] ^ $past(file[wr_idx])) & ~$past(wr_mask)) == '0);
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
    import cfl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [31:0]        instr,
    output logic               illegal_o,
    output logic [FILE_W-1:0]  cf_file_o
);
    decoded_t            dec;
    logic [FIELD_W-1:0]  rd_bf, rd_bfa, rd_bfb;
    logic [FIELD_W-1:0]  lut_res;
    logic                wr_en;
    logic                illegal_q;

    cfl_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec)
    );

    cfl_cfile #(.N(NUM_FIELDS), .W(FIELD_W)) u_file (
        .clk       (clk),
        .rst       (rst),
        .ra_idx    (dec.bf),
        .rb_idx    (dec.bfa),
        .rc_idx    (dec.bfb),
        .ra_data   (rd_bf),
        .rb_data   (rd_bfa),
        .rc_data   (rd_bfb),
        .wr_en     (wr_en),
        .wr_idx    (dec.bf),
        .wr_mask   (dec.mask),
        .wr_data   (lut_res),
        .file_flat (cf_file_o)
    );

    // One lookup per condition bit; the two-input table is the BFB field itself.
    for (genvar j = 0; j < FIELD_W; j++) begin : g_lane
        cfl_lut_lane u_lane (
            .kind (dec.kind),
            .tbl3 (dec.tbl3),
            .tbl2 (rd_bfb),
            .a    (rd_bf[j]),
            .b    (rd_bfa[j]),
            .c    (rd_bfb[j]),
            .r    (lut_res[j])
        );
    end

    assign wr_en = writes(dec.kind);

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= (dec.kind == OP_ILL);
    end

    assign illegal_o = illegal_q;

    assert_illegal_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> cf_file_o == $past(cf_file_o));

    assert_zero_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[22:21] == 2'b00 && instr[17:16] == 2'b00)
        |=> $stable(cf_file_o));

    assert_reset_flag_R1: assert property (@(posedge clk)
        rst |=> !illegal_o);
endmodule

// File: tb/sim_cfl_unit.sv
`timescale 1ns/1ps
module sim_cfl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        illegal_o;
    logic [31:0] cf_file_o;

    int checks = 0;
    int fails  = 0;
    logic drove = 1'b0;
    logic live  = 1'b0;
    logic done  = 1'b0;

    logic [3:0]  model [8];
    logic [31:0] exp_file_q [$];
    logic        exp_ill_q  [$];
    string       tag_q      [$];

    always #4 clk = ~clk;

    cfl_unit u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .illegal_o(illegal_o), .cf_file_o(cf_file_o)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] xo,
        input logic [2:0] bf, input logic [2:0] bfa, input logic [2:0] bfb,
        input logic [3:0] m, input logic [7:0] t);
        logic [31:0] w;
        w = '0;
        w[31:26] = op; w[25:23] = bf; w[22:21] = m[3:2]; w[20:18] = bfa;
        w[17:16] = m[1:0]; w[15:13] = bfb; w[12:6] = t[7:1]; w[5:1] = xo; w[0] = t[0];
        return w;
    endfunction

    function automatic logic [31:0] model_flat();
        logic [31:0] f;
        for (int k = 0; k < 8; k++) f[k*4 +: 4] = model[k];
        return f;
    endfunction

    // Reference behaviour built from R2..R10.
    function automatic logic model_step(input logic v, input logic [31:0] w);
        logic [3:0] a, b, c, m, nv;
        logic [7:0] t;
        if (!v) return 1'b0;
        if (w[31:26] != 6'd22 || (w[5:1] != 5'd10 && w[5:1] != 5'd11)) return 1'b1;
        a = model[w[25:23]]; b = model[w[20:18]]; c = model[w[15:13]];
        m = {w[22:21], w[17:16]};
        t = {w[12:6], w[0]};
        nv = a;
        for (int j = 0; j < 4; j++) begin
            if (m[j]) nv[j] = (w[5:1] == 5'd10) ? t[{a[j], b[j], c[j]}] : c[{a[j], b[j]}];
        end
        model[w[25:23]] = nv;
        return 1'b0;
    endfunction

    task automatic apply(input logic v, input logic [31:0] w, input string tag);
        logic ill;
        @(negedge clk);
        instr_valid = v;
        instr = w;
        ill = model_step(v, w);
        exp_file_q.push_back(model_flat());
        exp_ill_q.push_back(ill);
        tag_q.push_back(tag);
        drove = 1'b1;
    endtask

    always @(posedge clk) live <= drove;

    // Monitor: one queued expectation per sampled cycle, compared one edge later (R9).
    always @(negedge clk) begin
        if (live && exp_file_q.size() > 0) begin
            logic [31:0] ef;
            logic ei;
            string tg;
            ef = exp_file_q.pop_front();
            ei = exp_ill_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (cf_file_o !== ef || illegal_o !== ei) begin
                fails++;
                $display("FAIL %s: file=%h illegal=%b expected file=%h illegal=%b",
                         tg, cf_file_o, illegal_o, ef, ei);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    localparam logic [5:0] P  = 6'd22;
    localparam logic [4:0] XT = 5'd10;
    localparam logic [4:0] XB = 5'd11;

    initial begin
        logic [3:0] seeds [8];
        seeds = '{4'hA, 4'h3, 4'h5, 4'hC, 4'h9, 4'h6, 4'hF, 4'h1};
        for (int k = 0; k < 8; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cf_file_o !== 32'h0 || illegal_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: file=%h illegal=%b expected file=0 illegal=0", cf_file_o, illegal_o);
        end
        rst = 1'b0;

        // Seed each field: table all ones, mask picks the bits to set (R3, R5).
        for (int k = 0; k < 8; k++)
            apply(1'b1, enc(P, XT, 3'(k), 3'(k), 3'(k), seeds[k], 8'hFF), "R3 seed");

        apply(1'b1, enc(P, XT, 3'd0, 3'd1, 3'd2, 4'hF, 8'h96), "R3 xor3");
        apply(1'b1, enc(P, XT, 3'd3, 3'd4, 3'd5, 4'hF, 8'hE8), "R3 majority");
        apply(1'b1, enc(P, XT, 3'd6, 3'd1, 3'd7, 4'hF, 8'h80), "R3 and3");
        apply(1'b1, enc(P, XT, 3'd2, 3'd6, 3'd4, 4'hF, 8'h0F), "R3 not-bf");
        apply(1'b1, enc(P, XT, 3'd1, 3'd1, 3'd1, 4'hF, 8'h01), "R10 alias nor");
        apply(1'b1, enc(P, XT, 3'd4, 3'd2, 3'd3, 4'b1001, 8'hFF), "R5 partial mask");
        apply(1'b1, enc(P, XT, 3'd5, 3'd0, 3'd6, 4'b0110, 8'h00), "R5 partial clear");
        apply(1'b1, enc(P, XT, 3'd6, 3'd0, 3'd1, 4'b0000, 8'h00), "R6 zero mask tern");
        apply(1'b1, enc(P, XB, 3'd0, 3'd3, 3'd2, 4'hF, 8'h00), "R4 binary");
        apply(1'b1, enc(P, XB, 3'd7, 3'd6, 3'd5, 4'hF, 8'hFF), "R7 reserved ones");
        apply(1'b1, enc(P, XB, 3'd3, 3'd3, 3'd3, 4'hF, 8'h5A), "R10 binary alias");
        apply(1'b1, enc(P, XB, 3'd2, 3'd1, 3'd4, 4'b0000, 8'hFF), "R6 zero mask bin");
        apply(1'b1, enc(6'd23, XT, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF), "R8 bad primary");
        apply(1'b1, enc(P, 5'd12, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF), "R8 bad extended");
        apply(1'b0, enc(P, XT, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF), "R8 strobe low");
        apply(1'b1, enc(P, XT, 3'd0, 3'd0, 3'd0, 4'hF, 8'h55), "R9 chain a");
        apply(1'b1, enc(P, XT, 3'd0, 3'd0, 3'd0, 4'hF, 8'h55), "R9 chain b");
        apply(1'b1, enc(P, XB, 3'd1, 3'd0, 3'd0, 4'hF, 8'h00), "R9 chain c");

        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            logic [4:0] xo;
            int pick;
            w = $urandom;
            pick = $urandom_range(0, 9);
            xo = (pick < 5) ? XT : (pick < 9) ? XB : 5'($urandom);
            w[31:26] = (pick == 9 && w[0]) ? 6'($urandom) : P;
            w[5:1] = xo;
            apply(pick != 8 || w[3], w, "R2 random mix");
        end

        @(negedge clk);
        drove = 1'b0;
        instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule